// File: doc/BRIEF.md
# Memory Device Test Access Port

This block is the boundary-scan test port of a memory device. A 16-state test controller advances on the rising edge of the test clock under the mode-select line, and it moves serial data between the data input and the data output. A 3-bit instruction decides which serial path sits between those two pins. The paths are a one-bit bypass stage, a 32-bit identification word assembled from revision, type and vendor fields, and a boundary chain whose length is a parameter. Each boundary cell captures one pin state and has an update latch that can drive a pin. The block has no dedicated test reset pin. A power-on reset, or five consecutive rising edges with mode-select high, returns the controller to its reset state and selects the identification path.

Two control outputs go to the functional logic. One forces every functional output into high impedance while the tri-state sample instruction is current. The other hands the pins to the boundary update latches while the external-test instruction is current. The serial interface is plain synchronous signalling with no handshake: every bit moves on a clock edge, and a source that is not ready cannot hold the transfer back. The serial output is retimed on the falling edge, and an enable flags the half cycles in which it carries data.

Top module: `mem_tap_top`

## Requirements
- R1: While `por_n` is low, the controller is held in its reset state, the instruction is identification (001), `tdo_oe`, `tdo`, `outputs_hiz`, `extest_sel` and every bit of `bsr_pin_out` are 0. The identification word is the first data path read after release.
- R2: Five consecutive rising edges with `tms` high reach the reset state from any state, and the instruction then becomes identification (001).
- R3: The controller follows the standard 16-state graph, with `tms` sampled on the rising edge. Every state can be reached from run-idle.
- R4: Instruction codes: 000 is external test (boundary path), 001 is identification, 010 is tri-state sample (boundary path), 100 is sample/preload (boundary path) and 111 is bypass. The unassigned codes 011, 101 and 110 behave exactly like bypass.
- R5: Capture-IR loads 001 into the instruction shifter, which then shifts out least significant bit first (1, 0, 0). A shifted code takes effect at the rising edge that leaves Update-IR.
- R6: The identification path captures {revision[2:0] at bits 31:29, type[16:0] at bits 28:12, vendor[10:0] at bits 11:1, 1 at bit 0} and shifts out bit 0 first.
- R7: The bypass path captures 0 and delays `tdi` by exactly one shift.
- R8: For the three boundary instructions, Capture-DR loads `bsr_pin_in`. Cell 0 sits next to `tdo` and `tdi` enters the top cell. Update-DR copies the chain to `bsr_pin_out`. Other instructions leave `bsr_pin_out` unchanged.
- R9: `outputs_hiz` is high exactly while 010 is the current instruction. `extest_sel` is high exactly while 000 is current, and the values already in the update latches are then presented unchanged.
- R10: `tdo` changes only on a falling edge of `tck`. `tdo_oe` is high only for the half cycles following a falling edge taken in Shift-DR or Shift-IR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| tms | input | 1 | Mode select, sampled on rising edge |
| tdi | input | 1 | Serial data in, sampled on rising edge |
| tdo | output | 1 | Serial data out, changes on falling edge |
| tdo_oe | output | 1 | High while `tdo` carries shifted data |
| bsr_pin_in | input | BSR_LEN | Pin states captured by the boundary chain |
| bsr_pin_out | output | BSR_LEN | Boundary update latches |
| extest_sel | output | 1 | Pins are driven from `bsr_pin_out` |
| outputs_hiz | output | 1 | Force all functional outputs to high impedance |

## Verification
The controller state cannot be seen at the ports, so the hardest case to produce is the five-high reset from each of the 16 states, and showing that each state was really reached. The bench first loads bypass. It then walks a fixed mode-select path from run-idle to each target state, where the output enable on the next cycle shows whether a shift state was reached. It then applies five high bits and reads the data path: an identification word instead of a one-bit delay shows that the reset took place. A sweep over all eight instruction codes compares each shifted stream with the value computed for that path's length and captured word.

// File: rtl/mem_tap_pkg.sv
`timescale 1ns/1ps
package mem_tap_pkg;

  localparam int IR_W = 3;

  typedef enum logic [3:0] {
    TS_RESET, TS_IDLE,
    TS_SEL_DR, TS_CAP_DR, TS_SHF_DR, TS_EX1_DR, TS_PAU_DR, TS_EX2_DR, TS_UPD_DR,
    TS_SEL_IR, TS_CAP_IR, TS_SHF_IR, TS_EX1_IR, TS_PAU_IR, TS_EX2_IR, TS_UPD_IR
  } tap_state_e;

  typedef enum logic [1:0] {DR_BYPASS, DR_IDENT, DR_BOUND} dr_sel_e;

  localparam logic [IR_W-1:0] OP_EXTEST  = 3'b000;
  localparam logic [IR_W-1:0] OP_IDCODE  = 3'b001;
  localparam logic [IR_W-1:0] OP_SAMPLEZ = 3'b010;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 3'b100;
  localparam logic [IR_W-1:0] OP_BYPASS  = 3'b111;
  localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

  function automatic tap_state_e tap_next(input tap_state_e s, input logic tms);
    case (s)
      TS_RESET:  return tms ? TS_RESET  : TS_IDLE;
      TS_IDLE:   return tms ? TS_SEL_DR : TS_IDLE;
      TS_SEL_DR: return tms ? TS_SEL_IR : TS_CAP_DR;
      TS_CAP_DR: return tms ? TS_EX1_DR : TS_SHF_DR;
      TS_SHF_DR: return tms ? TS_EX1_DR : TS_SHF_DR;
      TS_EX1_DR: return tms ? TS_UPD_DR : TS_PAU_DR;
      TS_PAU_DR: return tms ? TS_EX2_DR : TS_PAU_DR;
      TS_EX2_DR: return tms ? TS_UPD_DR : TS_SHF_DR;
      TS_UPD_DR: return tms ? TS_SEL_DR : TS_IDLE;
      TS_SEL_IR: return tms ? TS_RESET  : TS_CAP_IR;
      TS_CAP_IR: return tms ? TS_EX1_IR : TS_SHF_IR;
      TS_SHF_IR: return tms ? TS_EX1_IR : TS_SHF_IR;
      TS_EX1_IR: return tms ? TS_UPD_IR : TS_PAU_IR;
      TS_PAU_IR: return tms ? TS_EX2_IR : TS_PAU_IR;
      TS_EX2_IR: return tms ? TS_UPD_IR : TS_SHF_IR;
      TS_UPD_IR: return tms ? TS_SEL_DR : TS_IDLE;
      default:   return TS_RESET;
    endcase
  endfunction

  function automatic dr_sel_e dr_of(input logic [IR_W-1:0] op);
    case (op)
      OP_EXTEST, OP_SAMPLEZ, OP_SAMPLE: return DR_BOUND;
      OP_IDCODE:                        return DR_IDENT;
      default:                          return DR_BYPASS;
    endcase
  endfunction

endpackage

// File: rtl/mem_tap_fsm.sv
`timescale 1ns/1ps
module mem_tap_fsm
  import mem_tap_pkg::*;
(
  input  logic       tck,
  input  logic       por_n,
  input  logic       tms,
  output tap_state_e state
);

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) state <= TS_RESET;
    else        state <= tap_next(state, tms);
  end

endmodule

// File: rtl/mem_tap_ir.sv
`timescale 1ns/1ps
module mem_tap_ir
  import mem_tap_pkg::*;
(
  input  logic            tck,
  input  logic            por_n,
  input  logic            tdi,
  input  tap_state_e      state,
  output logic [IR_W-1:0] ir_q,
  output logic            ir_lsb
);

  logic [IR_W-1:0] ir_sr;

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) begin
      ir_sr <= IR_CAPTURE;
    end else if (state == TS_CAP_IR) begin
      ir_sr <= IR_CAPTURE;
    end else if (state == TS_SHF_IR) begin
      ir_sr <= {tdi, ir_sr[IR_W-1:1]};
    end
  end

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n)                  ir_q <= OP_IDCODE;
    else if (state == TS_RESET)  ir_q <= OP_IDCODE;
    else if (state == TS_UPD_IR) ir_q <= ir_sr;
  end

  assign ir_lsb = ir_sr[0];

endmodule

// File: rtl/mem_tap_dr.sv
`timescale 1ns/1ps
module mem_tap_dr
  import mem_tap_pkg::*;
#(
  parameter int          BSR_LEN = 109,
  parameter logic [31:0] ID_WORD = 32'h0000_0001
) (
  input  logic               tck,
  input  logic               por_n,
  input  logic               tdi,
  input  tap_state_e         state,
  input  dr_sel_e            dr_sel,
  input  logic [BSR_LEN-1:0] pin_in,
  output logic               dr_lsb,
  output logic [BSR_LEN-1:0] pin_out
);

  localparam int ID_W = 32;

  logic              cap_en, shf_en, upd_en;
  logic [ID_W-1:0]   id_sr;
  logic              byp_q;
  logic [BSR_LEN-1:0] bs_sr;
  logic [BSR_LEN:0]   chain;

  assign cap_en = (state == TS_CAP_DR);
  assign shf_en = (state == TS_SHF_DR);
  assign upd_en = (state == TS_UPD_DR);

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n)                            id_sr <= '0;
    else if (cap_en && dr_sel == DR_IDENT) id_sr <= ID_WORD;
    else if (shf_en && dr_sel == DR_IDENT) id_sr <= {tdi, id_sr[ID_W-1:1]};
  end

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n)                             byp_q <= 1'b0;
    else if (cap_en && dr_sel == DR_BYPASS) byp_q <= 1'b0;
    else if (shf_en && dr_sel == DR_BYPASS) byp_q <= tdi;
  end

  assign chain = {tdi, bs_sr};

  for (genvar g = 0; g < BSR_LEN; g++) begin : g_cell
    logic sr_c, upd_c;
    always_ff @(posedge tck or negedge por_n) begin
      if (!por_n)                            sr_c <= 1'b0;
      else if (cap_en && dr_sel == DR_BOUND) sr_c <= pin_in[g];
      else if (shf_en && dr_sel == DR_BOUND) sr_c <= chain[g+1];
    end
    always_ff @(posedge tck or negedge por_n) begin
      if (!por_n)                            upd_c <= 1'b0;
      else if (upd_en && dr_sel == DR_BOUND) upd_c <= sr_c;
    end
    assign bs_sr[g]   = sr_c;
    assign pin_out[g] = upd_c;
  end

  always_comb begin
    case (dr_sel)
      DR_IDENT: dr_lsb = id_sr[0];
      DR_BOUND: dr_lsb = bs_sr[0];
      default:  dr_lsb = byp_q;
    endcase
  end

endmodule

// File: rtl/mem_tap_top.sv
`timescale 1ns/1ps
module mem_tap_top
  import mem_tap_pkg::*;
#(
  parameter int          BSR_LEN   = 109,
  parameter logic [2:0]  ID_REV    = 3'h1,
  parameter logic [16:0] ID_TYPE   = 17'h0_5A36,
  parameter logic [10:0] ID_VENDOR = 11'h023
) (
  input  logic               tck,
  input  logic               por_n,
  input  logic               tms,
  input  logic               tdi,
  output logic               tdo,
  output logic               tdo_oe,
  input  logic [BSR_LEN-1:0] bsr_pin_in,
  output logic [BSR_LEN-1:0] bsr_pin_out,
  output logic               extest_sel,
  output logic               outputs_hiz
);

  localparam logic [31:0] ID_WORD = {ID_REV, ID_TYPE, ID_VENDOR, 1'b1};

  tap_state_e      state_q;
  logic [IR_W-1:0] ir_q;
  logic            ir_lsb, dr_lsb;
  dr_sel_e         dr_sel;

  mem_tap_fsm u_fsm (
    .tck(tck), .por_n(por_n), .tms(tms), .state(state_q)
  );

  mem_tap_ir u_ir (
    .tck(tck), .por_n(por_n), .tdi(tdi), .state(state_q),
    .ir_q(ir_q), .ir_lsb(ir_lsb)
  );

  assign dr_sel = dr_of(ir_q);

  mem_tap_dr #(.BSR_LEN(BSR_LEN), .ID_WORD(ID_WORD)) u_dr (
    .tck(tck), .por_n(por_n), .tdi(tdi), .state(state_q), .dr_sel(dr_sel),
    .pin_in(bsr_pin_in), .dr_lsb(dr_lsb), .pin_out(bsr_pin_out)
  );

  // Serial output retimed on the falling edge
  always_ff @(negedge tck or negedge por_n) begin
    if (!por_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= (state_q == TS_SHF_DR) || (state_q == TS_SHF_IR);
      tdo    <= (state_q == TS_SHF_IR) ? ir_lsb : dr_lsb;
    end
  end

  assign outputs_hiz = (ir_q == OP_SAMPLEZ);
  assign extest_sel  = (ir_q == OP_EXTEST);

endmodule

// File: rtl/mem_tap_chk.sv
`timescale 1ns/1ps
module mem_tap_chk
  import mem_tap_pkg::*;
(
  input logic            tck,
  input logic            por_n,
  input logic            tms,
  input logic            tdo,
  input logic            tdo_oe,
  input logic            outputs_hiz,
  input logic            extest_sel,
  input tap_state_e      state,
  input logic [IR_W-1:0] ir
);

  logic [2:0] ones_cnt;

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n)               ones_cnt <= 3'd0;
    else if (!tms)            ones_cnt <= 3'd0;
    else if (ones_cnt != 3'd5) ones_cnt <= ones_cnt + 3'd1;
  end

  p_five_high_r2: assert property (@(posedge tck) disable iff (!por_n)
    (ones_cnt == 3'd5) |-> (state == TS_RESET));

  p_reset_ident_r2: assert property (@(posedge tck) disable iff (!por_n)
    (state == TS_RESET) |=> (ir == OP_IDCODE));

  p_oe_shift_r10: assert property (@(posedge tck) disable iff (!por_n)
    tdo_oe |-> (state == TS_SHF_DR || state == TS_SHF_IR));

  p_hiz_update_r9: assert property (@(posedge tck) disable iff (!por_n)
    $rose(outputs_hiz) |-> ($past(state) == TS_UPD_IR));

  p_extest_update_r9: assert property (@(posedge tck) disable iff (!por_n)
    $rose(extest_sel) |-> ($past(state) == TS_UPD_IR));

  // R10: serial output only moves while the clock is low
  always @(tdo) begin
    if (por_n) a_tdo_fall_r10: assert (tck == 1'b0);
  end

endmodule

bind mem_tap_top mem_tap_chk u_chk (
  .tck(tck), .por_n(por_n), .tms(tms), .tdo(tdo), .tdo_oe(tdo_oe),
  .outputs_hiz(outputs_hiz), .extest_sel(extest_sel),
  .state(state_q), .ir(ir_q)
);

// File: tb/mem_tap_top_tb_top.sv
`timescale 1ns/1ps
module mem_tap_top_tb_top;

  localparam int          BSR = 12;
  localparam logic [2:0]  REV = 3'h5;
  localparam logic [16:0] TYP = 17'h1_ABCD;
  localparam logic [10:0] VEN = 11'h2A3;
  localparam logic [31:0] IDW = {REV, TYP, VEN, 1'b1};
  localparam int          NSH = 40;

  logic tck = 1'b0;
  logic por_n = 1'b0;
  logic tms = 1'b1;
  logic tdi = 1'b0;
  logic tdo, tdo_oe, extest_sel, outputs_hiz;
  logic [BSR-1:0] bsr_pin_in = '0;
  logic [BSR-1:0] bsr_pin_out;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;

  mem_tap_top #(.BSR_LEN(BSR), .ID_REV(REV), .ID_TYPE(TYP), .ID_VENDOR(VEN)) dut_i (
    .tck(tck), .por_n(por_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
    .bsr_pin_in(bsr_pin_in), .bsr_pin_out(bsr_pin_out),
    .extest_sel(extest_sel), .outputs_hiz(outputs_hiz)
  );

  always #2.5 tck = ~tck;

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  always @(posedge tck) begin
    cyc++;
    if (cyc > 150000) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      summary();
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One TCK period: drive after the falling edge, sample output before the rising edge
  task automatic step(input logic m, input logic d, output logic q, output logic oe);
    logic post;
    @(negedge tck); #0.5;
    tms = m; tdi = d;
    q = tdo; oe = tdo_oe;
    @(posedge tck); #0.5;
    post = tdo;
    if (oe) chk(post == q, "R10 tdo held over rising edge", {63'd0, post}, {63'd0, q});
  endtask

  task automatic go(input logic m);
    logic q, oe;
    step(m, 1'b0, q, oe);
  endtask

  task automatic load_ir(input logic [2:0] op, output logic [2:0] cap);
    logic q, oe;
    go(1); go(1); go(0); go(0);
    for (int i = 0; i < 3; i++) begin
      step(i == 2, op[i], q, oe);
      cap[i] = q;
      chk(oe, "R10 oe in Shift-IR", {63'd0, oe}, 64'd1);
    end
    go(1); go(0);
  endtask

  task automatic shift_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
    logic q, oe;
    int bad;
    bad = 0;
    dout = '0;
    go(1); go(0); go(0);
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i], q, oe);
      dout[i] = q;
      if (!oe) bad++;
    end
    chk(bad == 0, "R10 oe through Shift-DR", 64'(bad), 64'd0);
    go(1);
    step(1'b0, 1'b0, q, oe);
    chk(!oe, "R10 oe low outside shift", {63'd0, oe}, 64'd0);
  endtask

  function automatic logic [63:0] exp_shift(input int len, input logic [63:0] cap,
                                            input logic [63:0] din, input int n);
    logic [63:0] r;
    r = '0;
    for (int i = 0; i < n; i++) r[i] = (i < len) ? cap[i] : din[i-len];
    return r;
  endfunction

  function automatic int path_len(input int t);
    case (t)
      0: return 3;  1: return 0;  2: return 1;  3: return 2;
      4: return 3;  5: return 3;  6: return 4;  7: return 5;
      8: return 4;  9: return 2;  10: return 3; 11: return 4;
      12: return 4; 13: return 5; 14: return 6; default: return 5;
    endcase
  endfunction

  function automatic logic [5:0] path_bits(input int t);
    case (t)
      0: return 6'b000111;  1: return 6'b000000;  2: return 6'b000001;
      3: return 6'b000001;  4: return 6'b000001;  5: return 6'b000101;
      6: return 6'b000101;  7: return 6'b010101;  8: return 6'b001101;
      9: return 6'b000011;  10: return 6'b000011; 11: return 6'b000011;
      12: return 6'b001011; 13: return 6'b001011; 14: return 6'b101011;
      default: return 6'b011011;
    endcase
  endfunction

  initial begin
    logic [2:0]  cap;
    logic [63:0] din, dout, expv;
    logic [BSR-1:0] prev, pat;
    logic q, oe;
    int len;

    // R1 reset state
    repeat (3) @(posedge tck);
    #1;
    chk(!tdo_oe && !tdo, "R1 serial output idle in reset", {62'd0, tdo_oe, tdo}, 64'd0);
    chk(!outputs_hiz && !extest_sel, "R1 controls low in reset", {62'd0, outputs_hiz, extest_sel}, 64'd0);
    chk(bsr_pin_out == '0, "R1 update latches cleared", 64'(bsr_pin_out), 64'd0);
    @(negedge tck); por_n = 1'b1;
    go(0);
    din = 64'h0000_00F0_0F0F_3C3C;
    shift_dr(NSH, din, dout);
    expv = exp_shift(32, {32'd0, IDW}, din, NSH);
    chk(dout == expv, "R1 R6 identification after power-on", dout, expv);

    // R4 sweep of every instruction code
    for (int op = 0; op < 8; op++) begin
      load_ir(3'(op), cap);
      chk(cap == 3'b001, "R5 Capture-IR pattern", 64'(cap), 64'd1);
      chk(outputs_hiz == (op == 2), "R9 tri-state flag", {63'd0, outputs_hiz}, 64'(op == 2));
      chk(extest_sel == (op == 0), "R9 external test flag", {63'd0, extest_sel}, 64'(op == 0));
      bsr_pin_in = BSR'(12'hA5C ^ (op * 12'h111));
      prev = bsr_pin_out;
      din = 64'h9E37_79B9_7F4A_7C15 >> op;
      shift_dr(NSH, din, dout);
      if (op == 0 || op == 2 || op == 4) begin
        len = BSR; expv = exp_shift(len, 64'(bsr_pin_in), din, NSH);
        chk(dout == expv, "R4 R8 boundary capture and shift", dout, expv);
        chk(bsr_pin_out == din[NSH-BSR +: BSR], "R8 Update-DR latches", 64'(bsr_pin_out), 64'(din[NSH-BSR +: BSR]));
      end else begin
        if (op == 1) begin
          expv = exp_shift(32, {32'd0, IDW}, din, NSH);
          chk(dout == expv, "R4 R6 identification path", dout, expv);
        end else begin
          expv = exp_shift(1, 64'd0, din, NSH);
          chk(dout == expv, "R4 R7 bypass one-bit delay", dout, expv);
        end
        chk(bsr_pin_out == prev, "R8 latches untouched by other paths", 64'(bsr_pin_out), 64'(prev));
      end
    end

    // R8 R9 preload then external test
    load_ir(3'b100, cap);
    pat = BSR'(12'h6D3);
    shift_dr(BSR, 64'(pat), dout);
    chk(bsr_pin_out == pat, "R8 preload into latches", 64'(bsr_pin_out), 64'(pat));
    load_ir(3'b000, cap);
    chk(extest_sel, "R9 external test selected", {63'd0, extest_sel}, 64'd1);
    chk(bsr_pin_out == pat, "R9 preloaded values presented", 64'(bsr_pin_out), 64'(pat));
    load_ir(3'b010, cap);
    chk(outputs_hiz && !extest_sel, "R9 tri-state sample", {62'd0, outputs_hiz, extest_sel}, 64'd2);

    // R2 R3 reach every state, then five high edges
    for (int t = 0; t < 16; t++) begin
      load_ir(3'b111, cap);
      for (int k = 0; k < path_len(t); k++) go(path_bits(t)[k]);
      for (int k = 0; k < 5; k++) begin
        step(1'b1, 1'b0, q, oe);
        if (k == 0) chk(oe == (t == 4 || t == 11), "R3 state reached (shift flag)", {63'd0, oe}, 64'(t == 4 || t == 11));
      end
      go(0);
      din = 64'h0000_0055_AA33_CC0F ^ 64'(t);
      shift_dr(NSH, din, dout);
      expv = exp_shift(32, {32'd0, IDW}, din, NSH);
      chk(dout == expv, "R2 five high edges restore identification", dout, expv);
    end

    // R1 asynchronous reset mid-run
    @(negedge tck); #1;
    por_n = 1'b0;
    #1;
    chk(bsr_pin_out == '0 && !outputs_hiz && !extest_sel && !tdo_oe, "R1 asynchronous reset",
        {50'd0, bsr_pin_out, outputs_hiz, tdo_oe}, 64'd0);
    summary();
  end

endmodule